// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block drains a transmit ring of 8-byte descriptors kept in host memory. When it is enabled and a ring base is programmed, it reads the descriptor under its current pointer. If the host has handed that descriptor over, the block follows the chain of linked descriptors, gathers their buffers into a local packet store and then plays the packet out as a byte stream with an end marker. Ownership goes back to the host in two ways. Every chained descriptor after the head has its control word zeroed as soon as it is consumed. The head descriptor keeps its ownership flag until the whole packet has been handled, and then it alone is released, followed by a one-cycle interrupt.

A 32-bit word master port carries all descriptor reads, buffer reads and status writes. Each request is held until the memory acknowledges it. A small register port holds the ring base and the current descriptor pointer. Buffer addresses whose two top bits are both set are folded down into the low 30-bit space. Because the packet is stored whole before any byte leaves, a chain that breaks partway is dropped with nothing sent.

Top module: `tx_ring_gather`

## Requirements
- R1: A descriptor is two words at consecutive addresses. In word 0, bit 31 is the hand-over flag (1 = owned by the block), bit 30 means return to the ring base, bit 27 means the packet continues in the next descriptor, and bits 12:0 give the buffer length in bytes. Word 1 is the buffer byte address.
- R2: While the ring base register is zero, or `link_en` is low, the idle block issues no memory request.
- R3: A packet starts only if word 0 at the current pointer has bit 31 set. Otherwise the block writes nothing, raises no interrupt, leaves the pointer unchanged and polls again.
- R4: The packet bytes are the buffer bytes in chain order. Within each 32-bit memory word the bytes are taken little-endian, and an unaligned buffer start skips the leading bytes of its word. The bytes leave on `tx_data` on `tx_valid`/`tx_ready` handshakes, with `tx_last` on the final byte only, and are held while `tx_ready` is low.
- R5: A descriptor whose length field is zero adds no byte but is still consumed, released and stepped past.
- R6: A buffer address with bits 31:30 both 1 is used with those two bits cleared.
- R7: Each consumed descriptor after the head of a chain has its word 0 written to zero.
- R8: After each descriptor, the pointer becomes the ring base if bit 30 is set, and the descriptor address plus 8 otherwise. The chain goes on only while bit 27 is set.
- R9: If a chained descriptor lacks bit 31, the packet is dropped. No byte is sent, the head descriptor is left untouched, no interrupt is raised, and the pointer rests on the descriptor that was not handed over.
- R10: When a chain ends, a nonzero total is streamed out first. Then the head's word 0 is written back with only bit 31 cleared, and `irq` pulses for exactly one cycle. A chain whose total is zero sends no byte but is still released and signalled.
- R11: Register offset 0x04 holds the ring base and offset 0x08 the current pointer. Both can be read and written, both reset to zero, and any other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Output link enabled; no new packet is started while low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_data | output | 8 | Packet byte |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_last | output | 1 | Current byte is the final byte of the packet |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | One-cycle pulse when a packet has been released |

## Verification
Register reads are combinational, so they are sampled on the falling edge of the cycle in which the offset is driven. A register write becomes visible one cycle later. Each memory request is acknowledged one cycle after it appears and is taken by the block on the following edge. The interrupt comes one cycle after the acknowledge of the head write-back, and by then every byte of the packet has been handed over. For this reason the bench does not predict exact packet cycle counts. It waits for the interrupt counter to move (with a bound), lets the block settle for a few more cycles, and only then compares the collected bytes, the end-marker position, the host memory words and the pointer. The negative cases (nothing handed over, broken chain, disabled) are observed over a fixed window that is far longer than a full poll.

// File: rtl/tdg_pkg.sv
// Shared constants, engine state type and address fold-down helper for the
// transmit descriptor ring gatherer.
package tdg_pkg;
    localparam int OWN_BIT    = 31;
    localparam int WRAP_BIT   = 30;
    localparam int CONT_BIT   = 27;
    localparam int LEN_W      = 13;
    localparam int DESC_BYTES = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_W0, ST_W1, ST_FETCH, ST_UNPACK,
        ST_CLEAR, ST_NEXT, ST_SEND, ST_WB
    } eng_st_e;

    // Addresses in the top window (bits 31:30 both set) lose those bits.
    function automatic logic [31:0] fold_addr(input logic [31:0] a);
        return (a[31:30] == 2'b11) ? {2'b00, a[29:0]} : a;
    endfunction
endpackage

// File: rtl/tdg_regs.sv
// Register file: ring base and current descriptor pointer.
// Assumes: the engine's pointer update wins over a software write in the
// same cycle; unknown offsets read zero and ignore writes.
module tdg_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cur_ld,
    input  logic [31:0] cur_val,
    output logic [31:0] ring_start,
    output logic [31:0] cur_ptr
);
    localparam logic [3:0] OFS_BASE = 4'h4;
    localparam logic [3:0] OFS_CUR  = 4'h8;

    // Hold base and pointer; engine load has priority on the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_start <= '0;
            cur_ptr    <= '0;
        end else begin
            if (reg_we && reg_addr == OFS_BASE) ring_start <= reg_wdata;
            if (cur_ld)                         cur_ptr    <= cur_val;
            else if (reg_we && reg_addr == OFS_CUR) cur_ptr <= reg_wdata;
        end
    end

    // Combinational read decode.
    always_comb begin
        case (reg_addr)
            OFS_BASE: reg_rdata = ring_start;
            OFS_CUR:  reg_rdata = cur_ptr;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tdg_engine.sv
// Descriptor walker: polls the ring, reads descriptors and buffer words,
// unpacks bytes one per cycle into the packet store, releases descriptors
// and raises the completion interrupt.
// Assumes: one outstanding memory request, held until mem_ack; bytes past
// MAX_BYTES are dropped; link_en and ring base are sampled only when idle.
module tdg_engine
    import tdg_pkg::*;
#(
    parameter  int MAX_BYTES = 8192,
    localparam int ADDR_W    = $clog2(MAX_BYTES),
    localparam int CNT_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic [31:0]       ring_start,
    input  logic [31:0]       cur_ptr,
    output logic              cur_ld,
    output logic [31:0]       cur_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_byte,
    output logic              send_go,
    output logic [CNT_W-1:0]  send_len,
    input  logic              send_done,
    output logic              irq,
    output logic              busy
);
    eng_st_e            st, after_desc;
    logic [31:0]        desc_addr, head_addr, head_w0, buf_addr, word, next_desc;
    logic [LEN_W-1:0]   remain;
    logic               w_wrap, w_cont, is_head;
    logic [CNT_W-1:0]   total;

    // Next descriptor address and the state after a descriptor's data.
    always_comb begin
        next_desc  = w_wrap ? ring_start : desc_addr + 32'(DESC_BYTES);
        after_desc = is_head ? ST_NEXT : ST_CLEAR;
    end

    // Memory master, packet-store write and control outputs.
    always_comb begin
        mem_req = st inside {ST_W0, ST_W1, ST_FETCH, ST_CLEAR, ST_WB};
        mem_we  = st inside {ST_CLEAR, ST_WB};
        case (st)
            ST_W1:    mem_addr = desc_addr + 32'd4;
            ST_FETCH: mem_addr = {buf_addr[31:2], 2'b00};
            ST_WB:    mem_addr = head_addr;
            default:  mem_addr = desc_addr;
        endcase
        mem_wdata = (st == ST_WB) ? (head_w0 & ~(32'd1 << OWN_BIT)) : '0;
        wr_en     = (st == ST_UNPACK) && (total < CNT_W'(MAX_BYTES));
        wr_addr   = total[ADDR_W-1:0];
        wr_byte   = word[{buf_addr[1:0], 3'b000} +: 8];
        cur_ld    = (st == ST_NEXT);
        cur_val   = next_desc;
        send_go   = (st == ST_NEXT) && !w_cont && (total != '0);
        send_len  = total;
        busy      = (st != ST_IDLE);
    end

    // Walk state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            desc_addr <= '0;
            head_addr <= '0;
            head_w0   <= '0;
            buf_addr  <= '0;
            word      <= '0;
            remain    <= '0;
            w_wrap    <= 1'b0;
            w_cont    <= 1'b0;
            is_head   <= 1'b0;
            total     <= '0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (st)
                ST_IDLE: if (ring_start != '0 && link_en) begin
                    desc_addr <= cur_ptr;
                    head_addr <= cur_ptr;
                    is_head   <= 1'b1;
                    total     <= '0;
                    st        <= ST_W0;
                end
                ST_W0: if (mem_ack) begin
                    w_wrap <= mem_rdata[WRAP_BIT];
                    w_cont <= mem_rdata[CONT_BIT];
                    remain <= mem_rdata[LEN_W-1:0];
                    if (is_head) head_w0 <= mem_rdata;
                    st <= mem_rdata[OWN_BIT] ? ST_W1 : ST_IDLE;
                end
                ST_W1: if (mem_ack) begin
                    buf_addr <= fold_addr(mem_rdata);
                    st       <= (remain == '0) ? after_desc : ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    word <= mem_rdata;
                    st   <= ST_UNPACK;
                end
                ST_UNPACK: begin
                    if (wr_en) total <= total + 1'b1;
                    remain   <= remain - 1'b1;
                    buf_addr <= buf_addr + 32'd1;
                    if (remain == LEN_W'(1))         st <= after_desc;
                    else if (buf_addr[1:0] == 2'b11) st <= ST_FETCH;
                end
                ST_CLEAR: if (mem_ack) st <= ST_NEXT;
                ST_NEXT: begin
                    if (w_cont) begin
                        desc_addr <= next_desc;
                        is_head   <= 1'b0;
                        st        <= ST_W0;
                    end else begin
                        st <= (total != '0) ? ST_SEND : ST_WB;
                    end
                end
                ST_SEND: if (send_done) st <= ST_WB;
                ST_WB: if (mem_ack) begin
                    irq <= 1'b1;
                    st  <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tdg_pktbuf.sv
// Packet store and byte streamer: four byte-lane memories written one byte
// at a time, then read out in order under a valid/ready handshake.
// Assumes: MAX_BYTES is a power of two of at least 8; send_go only while idle.
module tdg_pktbuf #(
    parameter  int MAX_BYTES = 8192,
    localparam int ADDR_W    = $clog2(MAX_BYTES),
    localparam int CNT_W     = ADDR_W + 1,
    localparam int WORDS     = MAX_BYTES / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic              send_go,
    input  logic [CNT_W-1:0]  send_len,
    output logic              send_done,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready
);
    logic [3:0][7:0]    lane_rd;
    logic               sending;
    logic [ADDR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]   len_q;

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [7:0] mem [WORDS];
        // Write the byte whose address falls in this lane.
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr[1:0] == 2'(l)) mem[wr_addr[ADDR_W-1:2]] <= wr_byte;
        end
        assign lane_rd[l] = mem[rd_ptr[ADDR_W-1:2]];
    end

    // Stream outputs from the read pointer.
    always_comb begin
        tx_data  = lane_rd[rd_ptr[1:0]];
        tx_valid = sending;
        tx_last  = sending && ({1'b0, rd_ptr} == len_q - 1'b1);
    end

    // Read-out control: start, advance on handshake, finish on last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sending   <= 1'b0;
            rd_ptr    <= '0;
            len_q     <= '0;
            send_done <= 1'b0;
        end else begin
            send_done <= 1'b0;
            if (send_go) begin
                sending <= 1'b1;
                rd_ptr  <= '0;
                len_q   <= send_len;
            end else if (sending && tx_ready) begin
                if (tx_last) begin
                    sending   <= 1'b0;
                    send_done <= 1'b1;
                end else begin
                    rd_ptr <= rd_ptr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tx_ring_gather.sv
// Top of the transmit descriptor ring gatherer: register file, walk engine
// and packet store.
// Assumes: a single-requester word memory that acknowledges each request
// once; the sink may stall at any byte.
module tx_ring_gather #(
    parameter int MAX_BYTES = 8192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_en,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int ADDR_W = $clog2(MAX_BYTES);
    localparam int CNT_W  = ADDR_W + 1;

    logic [31:0]       ring_start, cur_ptr, cur_val;
    logic              cur_ld, wr_en, send_go, send_done, eng_busy;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_byte;
    logic [CNT_W-1:0]  send_len;

    tdg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_ld(cur_ld),
        .cur_val(cur_val), .ring_start(ring_start), .cur_ptr(cur_ptr)
    );

    tdg_engine #(.MAX_BYTES(MAX_BYTES)) u_engine (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .ring_start(ring_start),
        .cur_ptr(cur_ptr), .cur_ld(cur_ld), .cur_val(cur_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
        .send_go(send_go), .send_len(send_len), .send_done(send_done),
        .irq(irq), .busy(eng_busy)
    );

    tdg_pktbuf #(.MAX_BYTES(MAX_BYTES)) u_pktbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_byte(wr_byte), .send_go(send_go), .send_len(send_len),
        .send_done(send_done), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_ready(tx_ready)
    );
endmodule

// File: rtl/tx_ring_gather_chk.sv
// Protocol checker for the transmit descriptor ring gatherer, bound to the top.
module tx_ring_gather_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        link_en,
    input logic        eng_busy,
    input logic [31:0] ring_start,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic [7:0]  tx_data,
    input logic        tx_valid,
    input logic        tx_last,
    input logic        tx_ready,
    input logic        irq
);
    AST_NO_POLL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && (ring_start == '0 || !link_en)) |=> !mem_req); // R2
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R4
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4
    AST_STREAM_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> eng_busy); // R4
    AST_WRITE_NEVER_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10
    AST_IRQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_ack && mem_we)); // R10
endmodule

bind tx_ring_gather tx_ring_gather_chk u_chk (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .eng_busy(eng_busy),
    .ring_start(ring_start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
);

// File: tb/test_tx_ring_gather.sv
module test_tx_ring_gather;
    localparam logic [31:0] RS   = 32'h40;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] WRAP = 32'h4000_0000;
    localparam logic [31:0] CONT = 32'h0800_0000;

    typedef struct packed {
        logic [1:0]  idx;
        logic        two;
        logic [12:0] len0;
        logic [1:0]  off0;
        logic [12:0] len1;
        logic [1:0]  off1;
        logic        wrap;
        logic        hi;
        logic        bp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{idx:2'd0, two:1'b0, len0:13'd8,  off0:2'd0, len1:13'd0, off1:2'd0, wrap:1'b0, hi:1'b0, bp:1'b0},
        '{idx:2'd1, two:1'b0, len0:13'd13, off0:2'd3, len1:13'd0, off1:2'd0, wrap:1'b0, hi:1'b0, bp:1'b0},
        '{idx:2'd0, two:1'b1, len0:13'd5,  off0:2'd1, len1:13'd9, off1:2'd2, wrap:1'b0, hi:1'b0, bp:1'b0},
        '{idx:2'd2, two:1'b1, len0:13'd6,  off0:2'd0, len1:13'd0, off1:2'd0, wrap:1'b1, hi:1'b1, bp:1'b0},
        '{idx:2'd3, two:1'b0, len0:13'd0,  off0:2'd0, len1:13'd0, off1:2'd0, wrap:1'b1, hi:1'b0, bp:1'b0},
        '{idx:2'd0, two:1'b1, len0:13'd11, off0:2'd2, len1:13'd7, off1:2'd1, wrap:1'b0, hi:1'b0, bp:1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, link_en = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, mem_addr, mem_wdata;
    logic        mem_req, mem_we, tx_valid, tx_last, irq, tx_ready;
    logic [7:0]  tx_data;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        bp = 1'b0, tog = 1'b0;

    int errors = 0, checks = 0;
    int wr_cnt = 0, req_cyc = 0, irq_cnt = 0, rx_n = 0, last_cnt = 0, last_pos = -1;
    logic [31:0] hmem [1024];
    logic [7:0]  rx_buf [256];

    assign tx_ready = bp ? tog : 1'b1;

    tx_ring_gather i_tx_ring_gather (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready), .irq(irq)
    );

    initial forever #10 clk = ~clk;
    initial forever begin @(negedge clk); tog = ~tog; end

    // Host memory with one-cycle acknowledge, plus stream and interrupt monitors.
    initial forever begin
        @(posedge clk);
        if (mem_req) req_cyc++;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_rdata <= (mem_addr[31:12] != 0) ? 32'hDEAD_BEEF : hmem[mem_addr[11:2]];
            if (mem_we) begin
                wr_cnt++;
                if (mem_addr[31:12] == 0) hmem[mem_addr[11:2]] = mem_wdata;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (tx_valid && tx_ready) begin
            if (rx_n < 256) rx_buf[rx_n] = tx_data;
            if (tx_last) begin last_cnt++; last_pos = rx_n; end
            rx_n++;
        end
        if (irq) irq_cnt++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [7:0] pat(int a);
        return 8'(a * 13 + (a >> 8) * 7 + 5);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++)
            hmem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        for (int i = 16; i < 32; i++) hmem[i] = '0;
    endtask

    task automatic put_desc(int idx, logic [31:0] w0, logic [31:0] w1);
        hmem[(RS >> 2) + idx*2 + 1] = w1;
        hmem[(RS >> 2) + idx*2]     = w0;
    endtask

    task automatic wait_irq(int base, output bit got);
        got = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (irq_cnt != base) begin got = 1'b1; return; end
        end
    endtask

    initial begin
        logic [31:0] rd;
        int base, reqs, wrs;
        bit got;

        // Reset state (R11, R2)
        fill_mem();
        tick(5);
        rst_n = 1'b1;
        tick(2);
        reg_read(4'h4, rd); check_eq("R11", "reset ring base", rd, 32'h0);
        reg_read(4'h8, rd); check_eq("R11", "reset pointer", rd, 32'h0);
        check_eq("R2", "reset mem_req", {31'd0, mem_req}, 32'd0);
        check_eq("R10", "reset irq and tx_valid", {30'd0, irq, tx_valid}, 32'd0);

        // Register access (R11)
        reg_write(4'h4, 32'h0000_0120);
        reg_write(4'h8, 32'h0000_0128);
        reg_read(4'h4, rd); check_eq("R11", "ring base readback", rd, 32'h120);
        reg_read(4'h8, rd); check_eq("R11", "pointer readback", rd, 32'h128);
        reg_write(4'hC, 32'hFFFF_FFFF);
        reg_read(4'hC, rd); check_eq("R11", "unmapped offset", rd, 32'h0);

        // Base zero with link enabled: no access (R2)
        reg_write(4'h4, 32'h0);
        link_en = 1'b1; reqs = req_cyc;
        tick(40);
        check_eq("R2", "requests with zero base", 32'(req_cyc - reqs), 32'd0);

        // Link disabled with base set: no access (R2)
        link_en = 1'b0;
        reg_write(4'h4, RS);
        reg_write(4'h8, RS);
        reqs = req_cyc;
        tick(40);
        check_eq("R2", "requests with link off", 32'(req_cyc - reqs), 32'd0);

        // Head not handed over: polls only (R3)
        put_desc(0, 32'h0000_0010, 32'h200);
        reqs = req_cyc; wrs = wr_cnt; base = irq_cnt; rx_n = 0;
        link_en = 1'b1;
        tick(60);
        link_en = 1'b0;
        tick(10);
        check_eq("R3", "polling requests seen", 32'(req_cyc - reqs > 0), 32'd1);
        check_eq("R3", "writes while not handed over", 32'(wr_cnt - wrs), 32'd0);
        check_eq("R3", "irq while not handed over", 32'(irq_cnt - base), 32'd0);
        check_eq("R3", "bytes while not handed over", 32'(rx_n), 32'd0);
        reg_read(4'h8, rd); check_eq("R3", "pointer unchanged", rd, RS);

        // Broken chain: drop (R9), then resume at the stuck descriptor
        put_desc(0, OWN | CONT | 32'd5, 32'h200);
        put_desc(1, 32'h0, 32'h300);
        base = irq_cnt; rx_n = 0;
        link_en = 1'b1;
        tick(100);
        check_eq("R9", "irq on broken chain", 32'(irq_cnt - base), 32'd0);
        check_eq("R9", "bytes on broken chain", 32'(rx_n), 32'd0);
        check_eq("R9", "head left untouched", hmem[RS >> 2], OWN | CONT | 32'd5);
        reg_read(4'h8, rd); check_eq("R9", "pointer at stuck descriptor", rd, RS + 32'd8);
        put_desc(1, OWN | 32'd3, 32'h300);
        wait_irq(base, got);
        tick(3); link_en = 1'b0; tick(10);
        check_eq("R9", "resumed packet irq", {31'd0, got}, 32'd1);
        check_eq("R9", "resumed packet length", 32'(rx_n), 32'd3);
        for (int k = 0; k < 3; k++)
            check_eq("R4", "resumed packet byte", {24'd0, rx_buf[k]}, {24'd0, pat(32'h300 + k)});
        check_eq("R10", "resumed head released", hmem[(RS >> 2) + 2], 32'd3);

        // Vector table: chains, alignment, fold-down, zero length, wrap, stall
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            logic [31:0] a0, a1, w0a, w0b, exp_cur;
            int tot, bad_k;
            string tag;
            t = VECS[v];
            link_en = 1'b0; bp = t.bp;
            tick(4);
            fill_mem();
            a0  = 32'h200 + 32'(t.off0);
            a1  = 32'h600 + 32'(t.off1);
            w0a = OWN | (t.two ? CONT : (t.wrap ? WRAP : 32'h0)) | 32'(t.len0);
            w0b = OWN | (t.wrap ? WRAP : 32'h0) | 32'(t.len1);
            put_desc(int'(t.idx), w0a, t.hi ? (a0 | 32'hC000_0000) : a0);
            if (t.two) put_desc(int'(t.idx) + 1, w0b, a1);
            reg_write(4'h4, RS);
            reg_write(4'h8, RS + 32'(t.idx) * 8);
            rx_n = 0; last_cnt = 0; last_pos = -1; base = irq_cnt;
            link_en = 1'b1;
            wait_irq(base, got);
            tick(3); link_en = 1'b0; tick(10);

            tot = int'(t.len0) + (t.two ? int'(t.len1) : 0);
            tag = t.hi ? "R6" : ((t.len0 == 0 || (t.two && t.len1 == 0)) ? "R5" : "R4");
            exp_cur = t.wrap ? RS : RS + (32'(t.idx) + (t.two ? 32'd2 : 32'd1)) * 8;

            check_eq("R10", "one irq per packet", 32'(irq_cnt - base), 32'd1);
            check_eq(tag, "packet length", 32'(rx_n), 32'(tot));
            bad_k = -1;
            for (int k = 0; k < tot; k++) begin
                logic [7:0] e;
                e = (k < int'(t.len0)) ? pat(int'(a0) + k) : pat(int'(a1) + k - int'(t.len0));
                if (bad_k < 0 && rx_buf[k] !== e) bad_k = k;
            end
            check_eq(tag, "first bad byte index (none = -1)", 32'(bad_k), 32'hFFFF_FFFF);
            check_eq("R4", "end marker count and place",
                     {16'(last_cnt), 16'(last_pos)},
                     (tot != 0) ? {16'd1, 16'(tot - 1)} : {16'd0, 16'hFFFF});
            check_eq("R1/R10", "head word 0 after release",
                     hmem[(RS >> 2) + int'(t.idx) * 2], w0a & ~OWN);
            if (t.two)
                check_eq("R7", "chained word 0 zeroed",
                         hmem[(RS >> 2) + (int'(t.idx) + 1) * 2], 32'h0);
            reg_read(4'h8, rd); check_eq("R8", "pointer after packet", rd, exp_cur);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule